// File: doc/BRIEF.md
# Prioritized Interrupt Controller

This block collects a parameterized number of interrupt lines (up to the data bus width) into a single registered request for a processor. Each line is fixed at build time as edge sensitive (it latches a low-to-high transition) or level sensitive (it follows a high input). Latched lines are held in a status register. An enable register masks them bit by bit. A pending register shows the lines that are both latched and enabled. A vector register returns the index of the most urgent pending line, where a lower bit number means higher urgency.

A master control register has two bits. One gates the request output. The other selects where status bits come from: the hardware lines, or software writes to the status register. Software mode allows firmware to raise interrupts for testing or for inter-task signalling. Software clears a handled source by writing ones to an acknowledge register.

The register port is a plain word-addressed strobe interface. A write takes effect on the clock edge where the write enable is high. Read data is registered and appears one cycle after the address is presented. The inputs are assumed to be synchronous to the clock already.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After a synchronous reset, status, enable and master control read 0, the request output is low and the vector reads all ones.
- R2: An edge-configured line sets its status bit in the cycle it is high after having been low in the previous cycle, and the bit stays set after the line falls. The previous-value sampler keeps running in software mode, so holding a line high never produces a second edge.
- R3: A level-configured line sets its status bit on every clock edge where it is high in hardware mode.
- R4: Writing offset 3 (acknowledge) clears each status bit written as 1. In the same cycle, a clear wins over a set. A level line that is still high sets its bit again one clock later.
- R5: Offset 2 (enable) is read/write. Offset 1 (pending) reads status AND enable.
- R6: Offset 4 (vector) reads the index of the lowest-numbered pending bit, zero-extended, or all ones when nothing is pending.
- R7: Offset 5 bit 0 (output enable) gates the request. The request is a register that is high one cycle after output enable is set and some pending bit is set.
- R8: When offset 5 bit 1 (hardware select) is 0, the hardware lines are ignored and writes to offset 0 OR the written bits into status. When it is 1, writes to offset 0 are ignored.
- R9: Read data appears one cycle after the address. Offset 3 and offsets 6 and 7 read 0. Bits above the line count and above bit 1 of offset 5 read 0. Offset 0 is status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | NUM_IN | Interrupt lines, bit 0 most urgent |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register word offset |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data |
| irq_out | output | 1 | Registered interrupt request |

## Verification
The bench targets the cases where an acknowledge collides with an active source. If a level line is acknowledged while still high, the bit must read clear for exactly one read and then reappear. A design that let the set win would never show the gap, and a design that dropped level sensing would never refill the bit. An edge line that is held high across an acknowledge must stay clear, or a broken edge detector would re-fire. The bench also checks that the vector moves to the next source when the most urgent one is removed, and that masking leaves the vector at all ones. In software mode the bench drives hardware lines and expects them to have no effect. A random phase compares every cycle of the request and the read data against a model written from the requirements.

// File: rtl/pic_pkg.sv
package pic_pkg;
  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    SEL_STAT = 3'd0,
    SEL_PEND = 3'd1,
    SEL_ENAB = 3'd2,
    SEL_ACK  = 3'd3,
    SEL_VECT = 3'd4,
    SEL_MCTL = 3'd5
  } reg_sel_e;

  localparam int MCTL_OUT_BIT = 0;
  localparam int MCTL_HW_BIT  = 1;
  localparam int MCTL_W       = 2;
endpackage

// File: rtl/pic_sense.sv
module pic_sense #(
  parameter int NUM_IN = 8,
  parameter logic [NUM_IN-1:0] EDGE_MASK = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_IN-1:0] irq_in,
  input  logic              hw_en,
  output logic [NUM_IN-1:0] set_vec
);
  logic [NUM_IN-1:0] prev_q;
  logic [NUM_IN-1:0] raw;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= '0;
    else     prev_q <= irq_in;
  end

  for (genvar i = 0; i < NUM_IN; i++) begin : g_line
    if (EDGE_MASK[i]) begin : g_edge
      assign raw[i] = irq_in[i] & ~prev_q[i];
    end else begin : g_level
      assign raw[i] = irq_in[i];
    end
  end

  assign set_vec = hw_en ? raw : '0;
endmodule

// File: rtl/pic_prienc.sv
module pic_prienc #(
  parameter int NUM_IN = 8,
  parameter int IDX_W  = 3
) (
  input  logic [NUM_IN-1:0] req,
  output logic              hit,
  output logic [IDX_W-1:0]  idx
);
  always_comb begin
    hit = 1'b0;
    idx = '0;
    for (int i = NUM_IN - 1; i >= 0; i--) begin
      if (req[i]) begin
        hit = 1'b1;
        idx = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import pic_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int NUM_IN = 8,
  parameter logic [NUM_IN-1:0] EDGE_MASK = 8'hF0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_IN-1:0] irq_in,
  input  logic              bus_we,
  input  logic [2:0]        bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq_out
);
  localparam int IDX_W = (NUM_IN > 1) ? $clog2(NUM_IN) : 1;

  logic [NUM_IN-1:0] stat_q, en_q, stat_nxt;
  logic [NUM_IN-1:0] hw_set, sw_set, ack_clr, pend;
  logic [MCTL_W-1:0] men_q;
  logic              irq_q;
  logic [DATA_W-1:0] rdata_q, rd_mux;
  logic              hw_mode, hit;
  logic [IDX_W-1:0]  idx;
  logic              wr_stat, wr_enab, wr_ack, wr_mctl;

  assign hw_mode = men_q[MCTL_HW_BIT];

  pic_sense #(.NUM_IN(NUM_IN), .EDGE_MASK(EDGE_MASK)) u_sense (
    .clk(clk), .rst(rst), .irq_in(irq_in), .hw_en(hw_mode), .set_vec(hw_set)
  );

  assign pend = stat_q & en_q;

  pic_prienc #(.NUM_IN(NUM_IN), .IDX_W(IDX_W)) u_prio (
    .req(pend), .hit(hit), .idx(idx)
  );

  assign wr_stat = bus_we && (bus_addr == SEL_STAT);
  assign wr_enab = bus_we && (bus_addr == SEL_ENAB);
  assign wr_ack  = bus_we && (bus_addr == SEL_ACK);
  assign wr_mctl = bus_we && (bus_addr == SEL_MCTL);

  assign sw_set  = (wr_stat && !hw_mode) ? bus_wdata[NUM_IN-1:0] : '0;
  assign ack_clr = wr_ack ? bus_wdata[NUM_IN-1:0] : '0;
  // a clear in the same cycle as a set wins; a held level refills next cycle
  assign stat_nxt = (stat_q | hw_set | sw_set) & ~ack_clr;

  always_comb begin
    rd_mux = '0;
    case (bus_addr)
      SEL_STAT: rd_mux = DATA_W'(stat_q);
      SEL_PEND: rd_mux = DATA_W'(pend);
      SEL_ENAB: rd_mux = DATA_W'(en_q);
      SEL_VECT: rd_mux = hit ? DATA_W'(idx) : '1;
      SEL_MCTL: rd_mux = DATA_W'(men_q);
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stat_q  <= '0;
      en_q    <= '0;
      men_q   <= '0;
      irq_q   <= 1'b0;
      rdata_q <= '0;
    end else begin
      stat_q  <= stat_nxt;
      if (wr_enab) en_q  <= bus_wdata[NUM_IN-1:0];
      if (wr_mctl) men_q <= bus_wdata[MCTL_W-1:0];
      irq_q   <= men_q[MCTL_OUT_BIT] & (|pend);
      rdata_q <= rd_mux;
    end
  end

  assign bus_rdata = rdata_q;
  assign irq_out   = irq_q;
endmodule

// File: rtl/pic_checker.sv
module pic_checker #(
  parameter int DATA_W = 32,
  parameter int NUM_IN = 8,
  parameter int IDX_W  = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_we,
  input logic [2:0]        bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [NUM_IN-1:0] stat,
  input logic [NUM_IN-1:0] en,
  input logic [1:0]        men,
  input logic              irq,
  input logic              hit,
  input logic [IDX_W-1:0]  idx
);
  logic [NUM_IN-1:0] pend, below;
  assign pend  = stat & en;
  assign below = (NUM_IN'(1) << idx) - NUM_IN'(1);

  p_ack_clears_r4: assert property (@(posedge clk) disable iff (rst)
    (bus_we && bus_addr == 3'd3) |=> ((stat & $past(bus_wdata[NUM_IN-1:0])) == '0));

  p_en_hold_r5: assert property (@(posedge clk) disable iff (rst)
    !(bus_we && bus_addr == 3'd2) |=> $stable(en));

  p_vec_lowest_r6: assert property (@(posedge clk) disable iff (rst)
    hit |-> (pend[idx] && ((pend & below) == '0)));

  p_irq_raise_r7: assert property (@(posedge clk) disable iff (rst)
    (men[0] && (|pend)) |=> irq);

  p_irq_cause_r7: assert property (@(posedge clk) disable iff (rst)
    irq |-> $past(men[0] && (|pend)));

  p_sw_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    (!men[1] && !bus_we) |=> $stable(stat));
endmodule

bind prio_irq_ctrl pic_checker #(
  .DATA_W(DATA_W), .NUM_IN(NUM_IN), .IDX_W(IDX_W)
) u_chk (
  .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .stat(stat_q), .en(en_q), .men(men_q),
  .irq(irq_out), .hit(hit), .idx(idx)
);

// File: tb/prio_irq_ctrl_test.sv
module prio_irq_ctrl_test;
  localparam int DW = 32;
  localparam int NI = 8;
  localparam logic [NI-1:0] EM = 8'hF0;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [NI-1:0] irq_in = '0;
  logic          bus_we = 1'b0;
  logic [2:0]    bus_addr = '0;
  logic [DW-1:0] bus_wdata = '0;
  logic [DW-1:0] bus_rdata;
  logic          irq_out;

  int total = 0;
  int fails = 0;
  bit chk_on = 1'b0;
  bit done = 1'b0;

  prio_irq_ctrl #(.DATA_W(DW), .NUM_IN(NI), .EDGE_MASK(EM)) uut (
    .clk(clk), .rst(rst), .irq_in(irq_in), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq_out(irq_out)
  );

  always #10 clk = ~clk;

  task automatic check(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [DW-1:0] vec_of(logic [NI-1:0] p);
    for (int i = 0; i < NI; i++) if (p[i]) return DW'(i);
    return '1;
  endfunction

  // reference model built from the requirements
  logic [NI-1:0] m_stat, m_prev, m_en;
  logic [1:0]    m_men;
  logic          m_irq;
  logic [DW-1:0] m_rd;

  always @(posedge clk) begin
    logic [NI-1:0] set, clr, p;
    logic [DW-1:0] rd;
    if (rst) begin
      m_stat = '0; m_prev = '0; m_en = '0; m_men = '0; m_irq = 1'b0; m_rd = '0;
    end else begin
      p = m_stat & m_en;
      case (bus_addr)
        3'd0: rd = DW'(m_stat);
        3'd1: rd = DW'(p);
        3'd2: rd = DW'(m_en);
        3'd4: rd = vec_of(p);
        3'd5: rd = DW'(m_men);
        default: rd = '0;
      endcase
      set = '0;
      if (m_men[1]) begin
        for (int i = 0; i < NI; i++)
          set[i] = EM[i] ? (irq_in[i] && !m_prev[i]) : irq_in[i];
      end else if (bus_we && bus_addr == 3'd0) begin
        set = bus_wdata[NI-1:0];
      end
      clr = (bus_we && bus_addr == 3'd3) ? bus_wdata[NI-1:0] : '0;
      m_irq  = m_men[0] && (|p);
      m_rd   = rd;
      m_stat = (m_stat | set) & ~clr;
      m_prev = irq_in;
      if (bus_we && bus_addr == 3'd2) m_en  = bus_wdata[NI-1:0];
      if (bus_we && bus_addr == 3'd5) m_men = bus_wdata[1:0];
    end
  end

  always @(negedge clk) begin
    if (chk_on) begin
      check("R7 model irq", DW'(irq_out), DW'(m_irq));
      check("R9 model rdata", bus_rdata, m_rd);
    end
  end

  // both tasks start at a falling edge and return at the next one
  task automatic wr(logic [2:0] a, logic [DW-1:0] d);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(logic [2:0] a, logic [DW-1:0] exp, string req);
    bus_we = 1'b0; bus_addr = a;
    @(negedge clk);
    check(req, bus_rdata, exp);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", total - fails, total);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog: actual hung expected finish");
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk_on = 1'b1;
    check("R1 irq after reset", DW'(irq_out), '0);
    rd(3'd0, '0, "R1 status");
    rd(3'd1, '0, "R1 pending");
    rd(3'd2, '0, "R1 enable");
    rd(3'd4, '1, "R1 vector");
    rd(3'd5, '0, "R1 master");

    wr(3'd5, 32'h3);
    wr(3'd2, 32'hFF);
    // level line 2
    irq_in = 8'h04; @(negedge clk);
    rd(3'd0, 32'h04, "R3 level set");
    rd(3'd4, 32'd2, "R6 vector level");
    rd(3'd1, 32'h04, "R5 pending");
    wr(3'd3, 32'h04);
    rd(3'd0, 32'h00, "R4 ack gap");
    rd(3'd0, 32'h04, "R4 level refill");
    irq_in = 8'h00;
    wr(3'd3, 32'h04);
    rd(3'd0, 32'h00, "R3 level gone");
    // edge line 5 pulse
    irq_in = 8'h20; @(negedge clk);
    irq_in = 8'h00;
    rd(3'd0, 32'h20, "R2 edge held");
    wr(3'd3, 32'h20);
    // edge line 4 held across ack
    irq_in = 8'h10; @(negedge clk);
    wr(3'd3, 32'h10);
    rd(3'd0, 32'h00, "R2 no refire");
    rd(3'd0, 32'h00, "R2 no refire later");
    irq_in = 8'h00;
    // priority between 1 and 6
    irq_in = 8'h42; @(negedge clk);
    irq_in = 8'h02;
    rd(3'd4, 32'd1, "R6 lowest wins");
    irq_in = 8'h00;
    wr(3'd3, 32'h02);
    rd(3'd4, 32'd6, "R6 next source");
    // masking
    wr(3'd2, 32'hBF);
    rd(3'd1, 32'h00, "R5 masked pending");
    rd(3'd4, '1, "R6 none pending");
    rd(3'd0, 32'h40, "R5 status kept");
    check("R7 irq masked", DW'(irq_out), '0);
    wr(3'd2, 32'hFF);
    @(negedge clk);
    check("R7 irq raised", DW'(irq_out), 32'd1);
    wr(3'd5, 32'h2);
    check("R7 one cycle latency", DW'(irq_out), 32'd1);
    @(negedge clk);
    check("R7 output gated", DW'(irq_out), '0);
    // software mode
    wr(3'd3, 32'hFF);
    wr(3'd5, 32'h1);
    irq_in = 8'hFF; @(negedge clk); @(negedge clk);
    rd(3'd0, 32'h00, "R8 hw ignored");
    wr(3'd0, 32'h81);
    rd(3'd0, 32'h81, "R8 sw set");
    rd(3'd4, 32'd0, "R6 sw vector");
    wr(3'd3, 32'hFF);
    irq_in = 8'h00; @(negedge clk);
    wr(3'd5, 32'h3);
    wr(3'd0, 32'h08);
    rd(3'd0, 32'h00, "R8 hw mode write ignored");
    // map corners
    rd(3'd3, 32'h0, "R9 ack reads zero");
    rd(3'd6, 32'h0, "R9 unused offset");
    wr(3'd2, 32'hFFFF_FFFF);
    rd(3'd2, 32'hFF, "R9 enable width");
    wr(3'd5, 32'hFFFF_FFFF);
    rd(3'd5, 32'h3, "R9 master width");

    // random phase, compared against the model every cycle
    for (int n = 0; n < 4000; n++) begin
      bus_we    = ($urandom % 4) == 0;
      bus_addr  = 3'($urandom % 8);
      bus_wdata = $urandom;
      if (($urandom % 3) == 0) irq_in = NI'($urandom);
      @(negedge clk);
    end
    bus_we = 1'b0;
    @(negedge clk);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule